// File: doc/BRIEF.md
# Multi-channel PWM dimming generator

This block drives eighteen LED current sinks from one shared pulse-width timebase. Each channel holds an 8-bit duty value; its gate output is high for duty/256 of every period, so a duty of 0 never turns the channel on and 255 keeps it on for all but one step of the period. A single 8-bit counter serves every channel, so all channels start their on-time in the same clock cycle.

A clock-enable prescaler sets the step rate of that counter. It divides the system clock by one of two parameter ratios, picked by a select input: a fast default rate and a slow alternative, about 20:3 apart. Each channel also takes a 6-bit control code. Four legal codes enable the channel and pick one of four current fractions: full, 11/12, 9/12 or 7/12. The fraction leaves the block as a 2-bit scale code for the analog sink. Every other code turns the channel off. Three global controls can force every output off: an all-off bit, a software run bit and a hardware shutdown input that is active low.

Duty values are copied into per-channel shadow registers only when the counter wraps, so a write in mid-period never cuts a pulse short. Control codes and the global controls act on the next clock.

Top module: `pwm_dim_gen`

## Requirements
- R1: Once a duty value D (0 to 255) has been loaded, a channel's gate is high for exactly D×DIV clock cycles in every period of 256×DIV cycles, where DIV is the active prescaler ratio. D=0 gives no high cycles and D=255 gives 255/256 of the period.
- R2: All channels use one timebase. Every enabled channel with a nonzero duty goes high in the same clock cycle at the start of a period.
- R3: With slow_sel_i=0 the counter steps once every DIV_FAST clocks (default 3). With slow_sel_i=1 it steps once every DIV_SLOW clocks (default 20), so a period lasts 256×DIV clocks.
- R4: Control codes 0x10, 0x11, 0x12 and 0x13 enable the channel and set its 2-bit scale output to 0, 1, 2 and 3 (full, 11/12, 9/12, 7/12) one clock later.
- R5: A control code with its top two bits 00 (0x00 to 0x0F), or any code outside 0x10 to 0x13, forces the channel gate low and its scale output to 0 one clock later.
- R6: all_off_i=1 forces every gate low one clock later. all_off_i=0 lets the channels run.
- R7: sw_run_i=0 forces every gate low one clock later, and so does hw_shdn_ni=0.
- R8: A new duty value on duty_i reaches the channel's shadow register only when the counter wraps from 255 to 0. During the rest of the period the gate keeps following the previous value.
- R9: While rst_ni is low, every gate output and every scale output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_i | input | N_CH*8 | Duty values, channel k in bits [8k+7:8k] |
| code_i | input | N_CH*6 | Control codes, channel k in bits [6k+5:6k] |
| slow_sel_i | input | 1 | 0 selects the fast step rate, 1 the slow one |
| sw_run_i | input | 1 | Software run bit, 0 turns all gates off |
| all_off_i | input | 1 | Global off bit, 1 turns all gates off |
| hw_shdn_ni | input | 1 | Hardware shutdown, low turns all gates off |
| gate_o | output | N_CH | Per-channel PWM gate |
| scale_o | output | N_CH*2 | Per-channel current-scale code |

## Verification
The bench measures duty at both ends of the range. A duty of 0 must give no high cycles; a design that compared with <= would leave a one-step sliver. A duty of 255 must give exactly 255 steps; a comparator that was off by one would give either 256 or 254. The bench writes a duty value in mid-period and checks that the old on-time still holds until the wrap. A design that loaded duty at once would cut the pulse short or stretch it. The bench also drives illegal control codes (0x05, 0x0F, 0x14, 0x20, 0x3F) and each global off control one at a time. A decoder that matched only the top bits would let 0x14 drive an LED, and a gating term that was left out would keep the outputs running during shutdown. Finally, the bench switches the rate and measures the period, which catches a prescaler that ignored the select or swapped the two ratios.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    SCALE_FULL = 2'd0,
    SCALE_11   = 2'd1,
    SCALE_9    = 2'd2,
    SCALE_7    = 2'd3
  } scale_e;

  typedef struct packed {
    logic   on;
    scale_e scale;
  } chan_cfg_t;

  // only 0x10..0x13 enable a channel; anything else is a safe off
  function automatic chan_cfg_t decode_code(logic [CODE_W-1:0] code);
    chan_cfg_t cfg;
    cfg.on    = (code[CODE_W-1:2] == 4'b0100);
    cfg.scale = cfg.on ? scale_e'(code[1:0]) : SCALE_FULL;
    return cfg;
  endfunction
endpackage

// File: rtl/pwm_dim_prescale.sv
module pwm_dim_prescale #(
  parameter int DIV_FAST = 3,
  parameter int DIV_SLOW = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CNT_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = slow_i ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
  // >= so that a switch to a shorter ratio never overruns
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_dim_timebase.sv
module pwm_dim_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_dim_channel.sv
module pwm_dim_channel
  import pwm_dim_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic              wrap_i,
  input  logic              run_i,
  output logic              gate_o,
  output logic [1:0]        scale_o,
  output logic [DUTY_W-1:0] duty_act_o
);
  chan_cfg_t         cfg;
  logic [DUTY_W-1:0] duty_q;
  logic              gate_q;
  scale_e            scale_q;

  assign cfg        = decode_code(code_i);
  assign gate_o     = gate_q;
  assign scale_o    = scale_q;
  assign duty_act_o = duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (wrap_i) duty_q <= duty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      scale_q <= SCALE_FULL;
    end else begin
      gate_q  <= run_i && cfg.on && (cnt_i < duty_q);
      scale_q <= cfg.scale;
    end
  end
endmodule

// File: rtl/pwm_dim_gen.sv
module pwm_dim_gen
  import pwm_dim_pkg::*;
#(
  parameter int N_CH     = 18,
  parameter int DUTY_W   = 8,
  parameter int DIV_FAST = 3,
  parameter int DIV_SLOW = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CH*DUTY_W-1:0]   duty_i,
  input  logic [N_CH*CODE_W-1:0]   code_i,
  input  logic                     slow_sel_i,
  input  logic                     sw_run_i,
  input  logic                     all_off_i,
  input  logic                     hw_shdn_ni,
  output logic [N_CH-1:0]          gate_o,
  output logic [N_CH*2-1:0]        scale_o
);
  logic              tick;
  logic              period_wrap;
  logic [DUTY_W-1:0] cnt;
  logic              run;
  logic [N_CH*DUTY_W-1:0] duty_act_flat;

  assign run = sw_run_i && hw_shdn_ni && !all_off_i;

  pwm_dim_prescale #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slow_i(slow_sel_i),
    .tick_o(tick)
  );

  pwm_dim_timebase #(.CNT_W(DUTY_W)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .cnt_o (cnt),
    .wrap_o(period_wrap)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    pwm_dim_channel #(.DUTY_W(DUTY_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .duty_i    (duty_i[k*DUTY_W +: DUTY_W]),
      .code_i    (code_i[k*CODE_W +: CODE_W]),
      .cnt_i     (cnt),
      .wrap_i    (period_wrap),
      .run_i     (run),
      .gate_o    (gate_o[k]),
      .scale_o   (scale_o[k*2 +: 2]),
      .duty_act_o(duty_act_flat[k*DUTY_W +: DUTY_W])
    );
  end
endmodule

// File: rtl/pwm_dim_chk.sv
module pwm_dim_chk #(
  parameter int N_CH   = 18,
  parameter int DUTY_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH*6-1:0]      code_i,
  input logic                   sw_run_i,
  input logic                   all_off_i,
  input logic                   hw_shdn_ni,
  input logic [N_CH-1:0]        gate_o,
  input logic [N_CH*2-1:0]      scale_o,
  input logic                   wrap_i,
  input logic [N_CH*DUTY_W-1:0] duty_act_i
);
  a_r6_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off_i |=> (gate_o == '0));

  a_r7_sw_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_run_i |=> (gate_o == '0));

  a_r7_hw_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_shdn_ni |=> (gate_o == '0));

  a_r9_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (gate_o == '0 && scale_o == '0));

  for (genvar k = 0; k < N_CH; k++) begin : g_ck
    a_r5_code_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_i[k*6+2 +: 4] != 4'b0100) |=> (!gate_o[k] && scale_o[k*2 +: 2] == 2'd0));

    a_r4_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_i[k*6+2 +: 4] == 4'b0100) |=> (scale_o[k*2 +: 2] == $past(code_i[k*6 +: 2])));

    a_r1_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_act_i[k*DUTY_W +: DUTY_W] == '0) |=> !gate_o[k]);

    a_r8_load_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(duty_act_i[k*DUTY_W +: DUTY_W]) |-> $past(wrap_i));
  end
endmodule

bind pwm_dim_gen pwm_dim_chk #(.N_CH(N_CH), .DUTY_W(DUTY_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_i    (code_i),
  .sw_run_i  (sw_run_i),
  .all_off_i (all_off_i),
  .hw_shdn_ni(hw_shdn_ni),
  .gate_o    (gate_o),
  .scale_o   (scale_o),
  .wrap_i    (period_wrap),
  .duty_act_i(duty_act_flat)
);

// File: tb/pwm_dim_gen_test.sv
module pwm_dim_gen_test;
  localparam int N   = 18;
  localparam int DF  = 3;
  localparam int DS  = 20;

  typedef struct {
    string tag;
    int    ch;
    int    exp;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*8-1:0]  duty_v = '0;
  logic [N*6-1:0]  code_v = '0;
  logic            slow = 1'b0, sw_run = 1'b1, all_off = 1'b0, hw_n = 1'b1;
  logic [N-1:0]    gate;
  logic [N*2-1:0]  scale;

  int    n_chk = 0, n_fail = 0;
  int    duty_m [N];
  int    code_m [N];
  item_t exp_q [$];
  int    win_len;
  event  win_go, win_done;

  always #2.5 clk = ~clk;

  pwm_dim_gen #(.N_CH(N), .DUTY_W(8), .DIV_FAST(DF), .DIV_SLOW(DS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty_v), .code_i(code_v),
    .slow_sel_i(slow), .sw_run_i(sw_run), .all_off_i(all_off),
    .hw_shdn_ni(hw_n), .gate_o(gate), .scale_o(scale)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(int ch, int d, int c);
    duty_m[ch] = d;
    code_m[ch] = c;
    duty_v[ch*8 +: 8] = 8'(d);
    code_v[ch*6 +: 6] = 6'(c);
  endtask

  function automatic bit code_on(int c);
    return (c >= 'h10 && c <= 'h13);
  endfunction

  // monitor: counts gate-high cycles over one period, pops and compares
  always begin
    int cnt [N];
    item_t it;
    @(win_go);
    for (int k = 0; k < N; k++) cnt[k] = 0;
    repeat (win_len) begin
      @(negedge clk);
      for (int k = 0; k < N; k++) cnt[k] += gate[k];
    end
    while (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      chk(cnt[it.ch] == it.exp, $sformatf("%s ch%0d high cycles", it.tag, it.ch),
          cnt[it.ch], it.exp);
    end
    ->win_done;
  end

  // driver: pushes expected high-cycle counts, then opens a window
  task automatic run_window(string tag, int div);
    bit run;
    run = sw_run && hw_n && !all_off;
    for (int k = 0; k < N; k++) begin
      item_t it;
      it.tag = tag;
      it.ch  = k;
      it.exp = (run && code_on(code_m[k])) ? duty_m[k] * div : 0;
      exp_q.push_back(it);
    end
    win_len = 256 * div;
    ->win_go;
    @(win_done);
  endtask

  task automatic sync_rise(int ch);
    logic prev;
    prev = gate[ch];
    forever begin
      @(negedge clk);
      if (!prev && gate[ch]) break;
      prev = gate[ch];
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0, per;
    for (int k = 0; k < N; k++) set_ch(k, 0, 'h10);
    wait_clk(3);
    // R9: reset state
    chk(gate == '0, "R9 gate in reset", int'(gate), 0);
    chk(scale == '0, "R9 scale in reset", int'(scale), 0);
    rst_n = 1'b1;

    for (int k = 0; k < N; k++) set_ch(k, k * 15, 'h10);
    set_ch(1, 15, 'h11);
    set_ch(2, 30, 'h12);
    set_ch(3, 45, 'h13);
    wait_clk(2 * 256 * DF);

    // R1: duty sweep 0..255 in steps of 15
    run_window("R1 duty sweep", DF);

    // R4: scale codes
    chk(scale[0 +: 2] == 2'd0, "R4 scale 0x10", int'(scale[0 +: 2]), 0);
    chk(scale[2 +: 2] == 2'd1, "R4 scale 0x11", int'(scale[2 +: 2]), 1);
    chk(scale[4 +: 2] == 2'd2, "R4 scale 0x12", int'(scale[4 +: 2]), 2);
    chk(scale[6 +: 2] == 2'd3, "R4 scale 0x13", int'(scale[6 +: 2]), 3);

    // R2: shared timebase, all nonzero enabled channels rise together
    sync_rise(1);
    for (int k = 1; k < N; k++)
      chk(gate[k] == 1'b1, $sformatf("R2 ch%0d high at period start", k), int'(gate[k]), 1);

    // R5: illegal and off codes
    set_ch(5, 75, 'h05);
    set_ch(6, 90, 'h14);
    set_ch(7, 105, 'h3F);
    set_ch(8, 120, 'h20);
    set_ch(9, 135, 'h0F);
    wait_clk(2);
    for (int k = 5; k <= 9; k++)
      chk(scale[k*2 +: 2] == 2'd0, $sformatf("R5 ch%0d scale off", k), int'(scale[k*2 +: 2]), 0);
    run_window("R5 illegal codes", DF);
    for (int k = 5; k <= 9; k++) set_ch(k, k * 15, 'h10);

    // R6 / R7: global off controls
    all_off = 1'b1; wait_clk(2);
    run_window("R6 all off", DF);
    all_off = 1'b0; sw_run = 1'b0; wait_clk(2);
    run_window("R7 software off", DF);
    sw_run = 1'b1; hw_n = 1'b0; wait_clk(2);
    run_window("R7 hardware off", DF);
    hw_n = 1'b1; wait_clk(2);
    run_window("R6 running again", DF);

    // R8: duty change mid-period waits for the wrap
    sync_rise(17);
    wait_clk(20 * DF);
    set_ch(2, 200, 'h12);
    wait_clk(80 * DF);
    chk(gate[2] == 1'b0, "R8 old duty still active", int'(gate[2]), 0);
    sync_rise(17);
    run_window("R8 new duty after wrap", DF);

    // R3: period length at fast rate
    sync_rise(8);
    t0 = 0;
    sync_rise(8);
    per = 0;
    begin
      logic prev;
      prev = gate[8];
      forever begin
        @(negedge clk);
        per++;
        if (!prev && gate[8]) break;
        prev = gate[8];
      end
    end
    chk(per == 256 * DF, "R3 fast period", per, 256 * DF);

    // R3: slow rate
    slow = 1'b1;
    wait_clk(2 * 256 * DS);
    run_window("R3 slow rate", DS);
    sync_rise(8);
    per = t0;
    begin
      logic prev;
      prev = gate[8];
      forever begin
        @(negedge clk);
        per++;
        if (!prev && gate[8]) break;
        prev = gate[8];
      end
    end
    chk(per == 256 * DS, "R3 slow period", per, 256 * DS);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule